// File: doc/BRIEF.md
# Register Rename Map with Free List

This block renames one instruction per cycle. It translates two architectural source identifiers into physical register numbers through a map table. It reports the physical register the destination currently maps to, as the previous destination. It takes a fresh physical register from the head of a free list and makes that register the destination's new mapping. The previous destination travels with the instruction down the pipeline. When the instruction commits, that number comes back on the commit port and goes to the tail of the free list. The register is therefore released only at commit and never at rename.

All lookups are combinational against the state present before the clock edge. An instruction that reads and writes the same architectural register sees the mapping that existed before its own rename. Map and free-list updates take effect at the clock edge on which `renValid` and `renReady` are both high.

Top module: `rename_map`

## Requirements
- R1: After reset, architectural register i maps to physical register i for every i from 0 to 31.
- R2: `physA` and `physB` equal the map-table entries selected by `srcA` and `srcB` in the same cycle.
- R3: `prevDst` equals the mapping of `dstArch` held before the current cycle's update.
- R4: `physDst` is the head of the free list. After reset the free list holds physical registers 32 to 127 in ascending order, and each accepted rename removes exactly one entry.
- R5: After an accepted rename, the map entry for `dstArch` holds the `physDst` value that was given out, from the next cycle on.
- R6: When a source identifier equals `dstArch`, the source lookup returns the old mapping, which is the same value as `prevDst`.
- R7: `renReady` is low exactly when the free list is empty. A `renValid` while `renReady` is low changes neither the map nor the free list.
- R8: An asserted `commitValid` appends `commitPhys` at the tail of the free list. The register is handed out again only after every entry that was ahead of it.
- R9: A commit and an accepted rename in the same cycle both take effect, and the free-list occupancy is unchanged by that cycle.
- R10: A commit while the free list is empty does not make `renReady` high in that cycle. It does make `renReady` high in the next cycle, and `physDst` then equals the committed register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| renValid | input | 1 | An instruction requests renaming this cycle |
| renReady | output | 1 | Free list not empty; rename accepted when high |
| srcA | input | 5 | First source architectural register |
| srcB | input | 5 | Second source architectural register |
| dstArch | input | 5 | Destination architectural register |
| physA | output | 7 | Physical register for srcA |
| physB | output | 7 | Physical register for srcB |
| prevDst | output | 7 | Mapping of dstArch before this rename |
| physDst | output | 7 | Newly allocated physical destination |
| commitValid | input | 1 | A committing instruction returns a register |
| commitPhys | input | 7 | Physical register returned to the free list |

## Verification
Allocation at rename and release at commit can land on the same clock edge. The free-list head and tail then both move, and its occupancy must not change. The bench provokes this by drawing rename and commit requests independently each cycle. Commits are drawn from the previous-destination numbers the block itself reported. A behavioural model updates a queue and a mapping array; its predicted ready flag and next allocated register are compared every cycle, so a miscounted occupancy shows up as a wrong `renReady` or a wrong `physDst`. The harder variant is a commit that arrives while the list is empty with a rename already waiting. The bench drains the list to reach this case and then checks that `renReady` stays low in that cycle and rises in the following one.

// File: rtl/rename_pkg.sv
package rename_pkg;
  typedef struct packed {
    logic doAlloc;
    logic doFree;
  } renStrobe_t;
endpackage

// File: rtl/rename_ctrl.sv
module rename_ctrl
  import rename_pkg::*;
(
  input  logic       renValid,
  input  logic       commitValid,
  input  logic       freeEmpty,
  output logic       renReady,
  output renStrobe_t strobe
);
  always_comb begin
    renReady       = !freeEmpty;
    strobe.doAlloc = renValid && !freeEmpty;
    strobe.doFree  = commitValid;
  end
endmodule

// File: rtl/rename_dpath.sv
module rename_dpath
  import rename_pkg::*;
#(
  parameter int ARCH_REGS = 32,
  parameter int PHYS_REGS = 128,
  localparam int ARCH_W = $clog2(ARCH_REGS),
  localparam int PHYS_W = $clog2(PHYS_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  renStrobe_t        strobe,
  input  logic [ARCH_W-1:0] srcA,
  input  logic [ARCH_W-1:0] srcB,
  input  logic [ARCH_W-1:0] dstArch,
  input  logic [PHYS_W-1:0] commitPhys,
  output logic [PHYS_W-1:0] physA,
  output logic [PHYS_W-1:0] physB,
  output logic [PHYS_W-1:0] prevDst,
  output logic [PHYS_W-1:0] physDst,
  output logic              freeEmpty
);
  localparam int FREE_DEPTH = PHYS_REGS - ARCH_REGS;
  localparam int PTR_W      = $clog2(FREE_DEPTH);
  localparam int CNT_W      = $clog2(FREE_DEPTH + 1);

  logic [PHYS_W-1:0] mapTbl   [ARCH_REGS];
  logic [PHYS_W-1:0] freeSlot [FREE_DEPTH];
  logic [PTR_W-1:0]  headPtr, tailPtr;
  logic [CNT_W-1:0]  freeCnt;

  function automatic logic [PTR_W-1:0] bumpPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FREE_DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  // Lookups see pre-update state
  assign physA     = mapTbl[srcA];
  assign physB     = mapTbl[srcB];
  assign prevDst   = mapTbl[dstArch];
  assign physDst   = freeSlot[headPtr];
  assign freeEmpty = (freeCnt == '0);

  for (genvar i = 0; i < ARCH_REGS; i++) begin : gMap
    always_ff @(posedge clk) begin
      if (!rstN)
        mapTbl[i] <= PHYS_W'(i);
      else if (strobe.doAlloc && dstArch == ARCH_W'(i))
        mapTbl[i] <= physDst;
    end
  end

  for (genvar k = 0; k < FREE_DEPTH; k++) begin : gFree
    always_ff @(posedge clk) begin
      if (!rstN)
        freeSlot[k] <= PHYS_W'(ARCH_REGS + k);
      else if (strobe.doFree && tailPtr == PTR_W'(k))
        freeSlot[k] <= commitPhys;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
      freeCnt <= CNT_W'(FREE_DEPTH);
    end else begin
      if (strobe.doAlloc) headPtr <= bumpPtr(headPtr);
      if (strobe.doFree)  tailPtr <= bumpPtr(tailPtr);
      case ({strobe.doAlloc, strobe.doFree})
        2'b10:   freeCnt <= freeCnt - CNT_W'(1);
        2'b01:   freeCnt <= freeCnt + CNT_W'(1);
        default: freeCnt <= freeCnt;
      endcase
    end
  end

  assert_alloc_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doAlloc && !strobe.doFree) |=> freeCnt == $past(freeCnt) - CNT_W'(1));
  assert_map_install_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doAlloc |=> mapTbl[$past(dstArch)] == $past(physDst));
  assert_no_alloc_empty_R7: assert property (@(posedge clk) disable iff (!rstN)
    freeEmpty |-> !strobe.doAlloc);
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doFree && !strobe.doAlloc) |-> freeCnt < CNT_W'(FREE_DEPTH));
  assert_balanced_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doAlloc && strobe.doFree) |=> freeCnt == $past(freeCnt));
  assert_free_step_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doFree && !strobe.doAlloc) |=> !freeEmpty);
endmodule

// File: rtl/rename_map.sv
module rename_map
  import rename_pkg::*;
#(
  parameter int ARCH_REGS = 32,
  parameter int PHYS_REGS = 128,
  localparam int ARCH_W = $clog2(ARCH_REGS),
  localparam int PHYS_W = $clog2(PHYS_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              renValid,
  output logic              renReady,
  input  logic [ARCH_W-1:0] srcA,
  input  logic [ARCH_W-1:0] srcB,
  input  logic [ARCH_W-1:0] dstArch,
  output logic [PHYS_W-1:0] physA,
  output logic [PHYS_W-1:0] physB,
  output logic [PHYS_W-1:0] prevDst,
  output logic [PHYS_W-1:0] physDst,
  input  logic              commitValid,
  input  logic [PHYS_W-1:0] commitPhys
);
  renStrobe_t strobe;
  logic       freeEmpty;

  rename_ctrl uCtrl (
    .renValid    (renValid),
    .commitValid (commitValid),
    .freeEmpty   (freeEmpty),
    .renReady    (renReady),
    .strobe      (strobe)
  );

  rename_dpath #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .srcA       (srcA),
    .srcB       (srcB),
    .dstArch    (dstArch),
    .commitPhys (commitPhys),
    .physA      (physA),
    .physB      (physB),
    .prevDst    (prevDst),
    .physDst    (physDst),
    .freeEmpty  (freeEmpty)
  );
endmodule

// File: tb/tb_rename_map.sv
`timescale 1ns/1ps
module tb_rename_map;
  localparam int ARCH = 32;
  localparam int PHYS = 128;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rstN = 1'b0;
  logic       renValid = 1'b0, commitValid = 1'b0, renReady;
  logic [4:0] srcA = '0, srcB = '0, dstArch = '0;
  logic [6:0] physA, physB, prevDst, physDst, commitPhys = '0;

  rename_map dut (
    .clk(clk), .rstN(rstN), .renValid(renValid), .renReady(renReady),
    .srcA(srcA), .srcB(srcB), .dstArch(dstArch),
    .physA(physA), .physB(physB), .prevDst(prevDst), .physDst(physDst),
    .commitValid(commitValid), .commitPhys(commitPhys)
  );

  int mapRef[ARCH];
  int freeQ[$];
  int pend[$];
  int initLeft;
  int checks = 0, errors = 0;
  bit prevBoth = 0, prevCommitEmpty = 0, done = 0;

  task automatic chk(string tag, string what, logic [31:0] act, int exp);
    checks++;
    if (act !== 32'(exp)) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cycle(bit rv, int a, int b, int d, bit cv, int cp, string tagA);
    bit avail;
    @(negedge clk);
    renValid = rv; srcA = 5'(a); srcB = 5'(b); dstArch = 5'(d);
    commitValid = cv; commitPhys = 7'(cp);
    #1;
    avail = freeQ.size() > 0;
    chk(prevBoth ? "R9" : (prevCommitEmpty ? "R10" : "R7"), "renReady", 32'(renReady), int'(avail));
    chk(tagA, "physA", 32'(physA), mapRef[a]);
    chk("R2", "physB", 32'(physB), mapRef[b]);
    chk("R3", "prevDst", 32'(prevDst), mapRef[d]);
    if (avail) chk(initLeft == 0 ? "R8" : "R4", "physDst", 32'(physDst), freeQ[0]);
    @(posedge clk);
    prevBoth        = rv && cv && avail;
    prevCommitEmpty = cv && !avail;
    if (rv && avail) begin
      pend.push_back(mapRef[d]);
      mapRef[d] = freeQ.pop_front();
      if (initLeft > 0) initLeft--;
    end
    if (cv) freeQ.push_back(cp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int cp;
    bit rv, cv;
    for (int i = 0; i < ARCH; i++) mapRef[i] = i;
    for (int k = ARCH; k < PHYS; k++) freeQ.push_back(k);
    initLeft = PHYS - ARCH;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: identity map after reset
    for (int i = 0; i < ARCH; i++) cycle(0, i, ARCH - 1 - i, i, 0, 0, "R1");
    // R6 then R5: same-register read, then lookup of new mapping
    cycle(1, 7, 7, 7, 0, 0, "R6");
    cycle(0, 7, 3, 3, 0, 0, "R5");
    // Drain free list
    while (freeQ.size() > 0)
      cycle(1, $urandom_range(0, 31), $urandom_range(0, 31), $urandom_range(0, 31), 0, 0, "R2");
    // R7: stalled requests change nothing
    for (int s = 0; s < 3; s++) cycle(1, 9, 9, 9, 0, 0, "R7");
    // R10: commit while empty, rename waiting
    cp = pend.pop_front();
    cycle(1, 4, 5, 4, 1, cp, "R10");
    cycle(1, 4, 5, 4, 0, 0, "R10");
    // Mixed traffic: R9 overlaps, R8 recycling
    for (int n = 0; n < 4000; n++) begin
      rv = ($urandom_range(0, 9) < 6);
      cv = (pend.size() > 0) && ($urandom_range(0, 1) == 1);
      cp = cv ? pend.pop_front() : 0;
      begin
        int d = $urandom_range(0, 31);
        int a = ($urandom_range(0, 3) == 0) ? d : $urandom_range(0, 31);
        cycle(rv, a, $urandom_range(0, 31), d, cv, cp, (a == d) ? "R6" : "R2");
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule